// File: doc/BRIEF.md
# Three-Lane TMDS Word Expander

This block sits between the transmit FIFO and the output shift register of a high-speed serial transmitter. Each word taken from the FIFO is held and emitted to the output shifter one or more times. Between emissions the held word is rotated right. Raw words are emitted unchanged. Encoded words are turned into three 10-bit TMDS symbols, one per lane. Each lane takes its own rotated view of the held word and keeps a programmable number of bits counted down from bit 7. The lane passes that byte through a transition-minimising 8b/10b encoder that keeps its own running disparity.

Raw and encoded words use separate rotate amounts and separate emission counts, so one stream can mix pixel data with control words. When expansion is disabled, every FIFO word is forwarded once, untouched. Both data edges are valid/ready streams. A word is taken from the input only when no word is held, or in the same cycle that the last emission of the held word is accepted. The output word and its type stay stable for as long as out_ready is low. Configuration inputs are static while the transmitter is enabled.

Top module: `tmds_lane_expander`

## Requirements
- R1: While tx_en is low, out_valid goes low at the next clock and in_ready is low. After reset, both are low.
- R2: With xpnd_en low, each accepted word is emitted exactly once with the same value, and out_enc is 0, whatever in_enc says.
- R3: With xpnd_en high and in_enc low, the word is emitted raw_cnt times with out_enc 0. Between emissions it is rotated right by raw_rot bits. A raw_cnt of 0 means 32 emissions.
- R4: With xpnd_en and in_enc high, the word is emitted enc_cnt times with out_enc 1. Between emissions it is rotated right by enc_rot bits. An enc_cnt of 0 means 32 emissions.
- R5: Lane l reads its rotate amount from lane_rot[5l+4:5l] and its count code k from lane_nbits[3l+2:3l]. Lane l encodes bits 7:0 of the held word rotated right by that amount. Only bits 7 down to 7-k are kept, and the lower bits are forced to 0.
- R6: Each lane encodes its byte with the standard TMDS algorithm: an XOR or XNOR chain chosen by the byte's ones count, then conditional inversion driven by a signed running disparity that starts at 0. The disparity is always even.
- R7: In an encoded output word, lane 0 occupies bits 9:0, lane 1 bits 19:10 and lane 2 bits 29:20. Bits 31:30 are 0.
- R8: Lane disparities are cleared while tx_en is low. They change only when an encoded word is accepted at the output.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_enc hold, and in_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter run enable; low flushes the held word and the disparities |
| xpnd_en | input | 1 | 1 = expansion active, 0 = pass-through; static while tx_en is high |
| in_valid | input | 1 | FIFO word available |
| in_ready | output | 1 | Word taken on this clock when in_valid is also high |
| in_data | input | 32 | FIFO word |
| in_enc | input | 1 | Word type: 1 = encoded, 0 = raw |
| enc_rot | input | 5 | Rotate right between emissions of encoded words |
| enc_cnt | input | 5 | Emissions per encoded word (0 = 32) |
| raw_rot | input | 5 | Rotate right between emissions of raw words |
| raw_cnt | input | 5 | Emissions per raw word (0 = 32) |
| lane_rot | input | 15 | Per-lane rotate amounts, lane l at bits 5l+4:5l |
| lane_nbits | input | 9 | Per-lane kept-bit codes (k keeps k+1 bits), lane l at bits 3l+2:3l |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Output shifter accepts the word |
| out_data | output | 32 | Word for the output shifter |
| out_enc | output | 1 | Type of the word on out_data |

## Verification
The bench targets count fields of 0. A design that reads 0 literally would emit nothing, or one word, instead of 32. Lane masks at widths 1 and 4 and lane rotates that wrap past bit 31 are exercised; a mask anchored at bit 0, or a plain shift in place of a rotate, corrupts the symbols. A long random stream of encoded words is compared symbol by symbol against an independent TMDS model, so any slip in the disparity update shows up within a few words. A stall holds the output for several cycles: a design that advances its disparity or its rotation without a handshake emits wrong symbols after the stall. Dropping tx_en between words must zero every lane's disparity; a design that does not zero it emits wrong symbols on the next words.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;
  localparam int NB_W   = 3;
  localparam int DISP_W = 8;

  typedef enum logic {
    KIND_RAW = 1'b0,
    KIND_ENC = 1'b1
  } word_kind_e;
endpackage

// File: rtl/tmx_lane_pick.sv
// Rotate the held word right and keep the top bits of its low byte.
module tmx_lane_pick
  import tmx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int ROT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [ROT_W-1:0]  rot,
  input  logic [NB_W-1:0]   nbits,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int EXT_W = WORD_W + BYTE_W - 1;

  logic [EXT_W-1:0]  ext;
  logic [BYTE_W-1:0] rotated;
  logic [BYTE_W-1:0] keep;

  // Wrap the low bits above the word so a window at any offset is a rotate.
  assign ext     = {word[BYTE_W-2:0], word};
  assign rotated = ext[rot +: BYTE_W];
  // Code k keeps bits 7 down to 7-k.
  assign keep    = 8'hFF << (3'd7 - nbits);
  assign byte_o  = rotated & keep;
endmodule

// File: rtl/tmx_tmds_lane.sv
// One TMDS lane: transition-minimising stage plus DC balancing with disparity.
module tmx_tmds_lane
  import tmx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     adv,
  input  logic [BYTE_W-1:0]        din,
  output logic [SYM_W-1:0]         sym,
  output logic signed [DISP_W-1:0] disp
);
  logic [3:0]               ones_in;
  logic                     use_xnor;
  logic [BYTE_W:0]          qm;
  logic [3:0]               ones_qm;
  logic signed [DISP_W-1:0] bal;
  logic signed [DISP_W-1:0] disp_nxt;
  logic signed [DISP_W-1:0] two;

  assign two = DISP_W'(2);

  always_comb begin
    ones_in  = 4'($countones(din));
    use_xnor = (ones_in > 4'd4) || ((ones_in == 4'd4) && !din[0]);
    qm[0]    = din[0];
    for (int i = 1; i < BYTE_W; i++) begin
      qm[i] = use_xnor ? ~(qm[i-1] ^ din[i]) : (qm[i-1] ^ din[i]);
    end
    qm[BYTE_W] = !use_xnor;
    ones_qm    = 4'($countones(qm[BYTE_W-1:0]));
    // ones minus zeros of the transition-minimised byte
    bal        = $signed({{(DISP_W-5){1'b0}}, ones_qm, 1'b0}) - DISP_W'(8);
  end

  always_comb begin
    if (disp == '0 || bal == '0) begin
      sym      = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      disp_nxt = qm[8] ? disp + bal : disp - bal;
    end else if ((disp > 0 && bal > 0) || (disp < 0 && bal < 0)) begin
      sym      = {1'b1, qm[8], ~qm[7:0]};
      disp_nxt = disp + (qm[8] ? two : '0) - bal;
    end else begin
      sym      = {1'b0, qm[8], qm[7:0]};
      disp_nxt = disp - (qm[8] ? '0 : two) + bal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   disp <= '0;
    else if (clr) disp <= '0;
    else if (adv) disp <= disp_nxt;
  end
endmodule

// File: rtl/tmx_word_seq.sv
// Holds one FIFO word and emits it the configured number of times,
// rotating it between emissions; type-dependent rotate and count.
module tmx_word_seq
  import tmx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int ROT_W = $clog2(WORD_W),
  localparam int CNT_W = ROT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              xpnd_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_enc,
  input  logic [ROT_W-1:0]  enc_rot,
  input  logic [ROT_W-1:0]  enc_cnt,
  input  logic [ROT_W-1:0]  raw_rot,
  input  logic [ROT_W-1:0]  raw_cnt,
  input  logic              out_ready,
  output logic              busy,
  output logic [WORD_W-1:0] hold,
  output word_kind_e        kind,
  output logic              fire
);
  logic [CNT_W-1:0]  left;
  logic [CNT_W-1:0]  load_cnt;
  logic [ROT_W-1:0]  step;
  logic [CNT_W-1:0]  back;
  logic [WORD_W-1:0] hold_rot;
  logic              last;
  word_kind_e        in_kind;

  assign in_kind  = (xpnd_en && in_enc) ? KIND_ENC : KIND_RAW;
  assign fire     = busy && out_ready;
  assign last     = (left == CNT_W'(1));
  assign in_ready = tx_en && (!busy || (fire && last));

  always_comb begin
    if (!xpnd_en)
      load_cnt = CNT_W'(1);
    else if (in_kind == KIND_ENC)
      load_cnt = (enc_cnt == '0) ? CNT_W'(WORD_W) : {1'b0, enc_cnt};
    else
      load_cnt = (raw_cnt == '0) ? CNT_W'(WORD_W) : {1'b0, raw_cnt};
  end

  assign step     = (kind == KIND_ENC) ? enc_rot : raw_rot;
  assign back     = CNT_W'(WORD_W) - {1'b0, step};
  assign hold_rot = (hold >> step) | (hold << back);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hold <= '0;
      left <= '0;
      kind <= KIND_RAW;
    end else if (!tx_en) begin
      busy <= 1'b0;
      left <= '0;
    end else if (in_valid && in_ready) begin
      busy <= 1'b1;
      hold <= in_data;
      left <= load_cnt;
      kind <= in_kind;
    end else if (fire) begin
      if (last) begin
        busy <= 1'b0;
        left <= '0;
      end else begin
        hold <= hold_rot;
        left <= left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tmds_lane_expander.sv
module tmds_lane_expander
  import tmx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 3,
  localparam int ROT_W = $clog2(WORD_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_en,
  input  logic                    xpnd_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_data,
  input  logic                    in_enc,
  input  logic [ROT_W-1:0]        enc_rot,
  input  logic [ROT_W-1:0]        enc_cnt,
  input  logic [ROT_W-1:0]        raw_rot,
  input  logic [ROT_W-1:0]        raw_cnt,
  input  logic [LANES*ROT_W-1:0]  lane_rot,
  input  logic [LANES*NB_W-1:0]   lane_nbits,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data,
  output logic                    out_enc
);
  logic                       busy;
  logic                       fire;
  logic [WORD_W-1:0]          hold;
  word_kind_e                 kind;
  logic                       adv;
  logic [SYM_W-1:0]           sym_arr [LANES];
  logic [LANES*DISP_W-1:0]    disp_flat;
  logic [WORD_W-1:0]          enc_word;

  tmx_word_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .xpnd_en(xpnd_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_enc(in_enc), .enc_rot(enc_rot), .enc_cnt(enc_cnt),
    .raw_rot(raw_rot), .raw_cnt(raw_cnt), .out_ready(out_ready),
    .busy(busy), .hold(hold), .kind(kind), .fire(fire)
  );

  assign adv = fire && (kind == KIND_ENC);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0]        lane_byte;
    logic signed [DISP_W-1:0] lane_disp;

    tmx_lane_pick #(.WORD_W(WORD_W)) u_pick (
      .word(hold), .rot(lane_rot[l*ROT_W +: ROT_W]),
      .nbits(lane_nbits[l*NB_W +: NB_W]), .byte_o(lane_byte)
    );

    tmx_tmds_lane u_tmds (
      .clk(clk), .rst_n(rst_n), .clr(!tx_en), .adv(adv),
      .din(lane_byte), .sym(sym_arr[l]), .disp(lane_disp)
    );

    assign disp_flat[l*DISP_W +: DISP_W] = lane_disp;
  end

  always_comb begin
    enc_word = '0;
    for (int l = 0; l < LANES; l++) begin
      enc_word[l*SYM_W +: SYM_W] = sym_arr[l];
    end
  end

  assign out_valid = busy;
  assign out_enc   = (kind == KIND_ENC);
  assign out_data  = (kind == KIND_ENC) ? enc_word : hold;
endmodule

// File: rtl/tmds_lane_expander_chk.sv
module tmds_lane_expander_chk
  import tmx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tx_en,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [WORD_W-1:0]       out_data,
  input logic                    out_enc,
  input logic [LANES*DISP_W-1:0] disp_flat
);
  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !out_valid);

  // R1
  no_take_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_enc));

  // R9
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  disp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> disp_flat == '0);

  // R8
  disp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !(out_valid && out_ready && out_enc) |=> $stable(disp_flat));

  for (genvar l = 0; l < LANES; l++) begin : g_even
    // R6
    disp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_flat[l*DISP_W] == 1'b0);
  end
endmodule

bind tmds_lane_expander tmds_lane_expander_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_enc(out_enc), .disp_flat(disp_flat)
);

// File: tb/tmds_lane_expander_bench.sv
`timescale 1ns/1ps
module tmds_lane_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        xpnd_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_enc = 1'b0;
  logic [4:0]  enc_rot = '0, enc_cnt = 5'd1, raw_rot = '0, raw_cnt = 5'd1;
  logic [14:0] lane_rot = '0;
  logic [8:0]  lane_nbits = '1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_enc;

  int n_chk = 0;
  int n_bad = 0;
  int mdisp [3];

  always #2.5 clk = ~clk;

  tmds_lane_expander u_tmds_lane_expander (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .xpnd_en(xpnd_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_enc(in_enc),
    .enc_rot(enc_rot), .enc_cnt(enc_cnt), .raw_rot(raw_rot), .raw_cnt(raw_cnt),
    .lane_rot(lane_rot), .lane_nbits(lane_nbits), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_enc(out_enc)
  );

  // {enc, cnt, rot, lane_rot{l2,l1,l0}, lane_nbits{l2,l1,l0}, data}
  localparam int NV = 8;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 5'd1,  5'd0,  5'd0,  5'd0,  5'd0,  3'd7, 3'd7, 3'd7, 32'hA5A5_0F0F},
    {1'b0, 5'd3,  5'd8,  5'd0,  5'd0,  5'd0,  3'd7, 3'd7, 3'd7, 32'h1234_5678},
    {1'b1, 5'd1,  5'd0,  5'd16, 5'd8,  5'd0,  3'd7, 3'd7, 3'd7, 32'h00C3_7E81},
    {1'b1, 5'd2,  5'd24, 5'd0,  5'd0,  5'd0,  3'd7, 3'd3, 3'd0, 32'hFFFF_FFFF},
    {1'b1, 5'd4,  5'd8,  5'd5,  5'd13, 5'd27, 3'd6, 3'd2, 3'd4, 32'hDEAD_BEEF},
    {1'b0, 5'd0,  5'd1,  5'd0,  5'd0,  5'd0,  3'd7, 3'd7, 3'd7, 32'h8000_0001},
    {1'b1, 5'd0,  5'd3,  5'd30, 5'd1,  5'd12, 3'd7, 3'd5, 3'd1, 32'h0F1E_2D3C},
    {1'b1, 5'd1,  5'd0,  5'd0,  5'd0,  5'd0,  3'd7, 3'd7, 3'd7, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ror32(input logic [31:0] v, input int s);
    logic [31:0] r;
    r = v;
    for (int i = 0; i < s; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  // Independent TMDS reference, updates the model disparity of lane l.
  function automatic logic [9:0] ref_tmds(input logic [7:0] d, input int l);
    int n1, ones, zeros, c;
    logic xn;
    logic [8:0] qm;
    logic [9:0] o;
    n1 = 0;
    for (int i = 0; i < 8; i++) n1 += d[i];
    xn = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
    qm[0] = d[0];
    for (int i = 1; i < 8; i++) qm[i] = xn ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    qm[8] = ~xn;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += qm[i];
    zeros = 8 - ones;
    c = mdisp[l];
    if (c == 0 || ones == zeros) begin
      o = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      c = qm[8] ? c + ones - zeros : c + zeros - ones;
    end else if ((c > 0 && ones > zeros) || (c < 0 && zeros > ones)) begin
      o = {1'b1, qm[8], ~qm[7:0]};
      c = c + 2 * int'(qm[8]) + zeros - ones;
    end else begin
      o = {1'b0, qm[8], qm[7:0]};
      c = c - 2 * int'(!qm[8]) + ones - zeros;
    end
    mdisp[l] = c;
    return o;
  endfunction

  function automatic logic [31:0] ref_enc(input logic [31:0] h);
    logic [31:0] w, r;
    logic [7:0] m;
    w = '0;
    for (int l = 0; l < 3; l++) begin
      r = ror32(h, int'(lane_rot[l*5 +: 5]));
      m = 8'hFF << (7 - int'(lane_nbits[l*3 +: 3]));
      w[l*10 +: 10] = ref_tmds(r[7:0] & m, l);
    end
    return w;
  endfunction

  task automatic push(input logic [31:0] d, input logic e);
    in_data = d; in_enc = e; in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_word(input logic [31:0] d, input logic e, input int stall, input string tag);
    int n, c;
    logic k;
    logic [31:0] h, ex;
    k = xpnd_en && e;
    if (!xpnd_en) n = 1;
    else begin
      c = k ? int'(enc_cnt) : int'(raw_cnt);
      n = (c == 0) ? 32 : c;
    end
    push(d, e);
    h = d;
    for (int i = 0; i < n; i++) begin
      ex = k ? ref_enc(h) : h;
      if (i == 0) begin
        for (int s = 0; s < stall; s++) begin
          out_ready = 1'b0;
          #1;
          chk({tag, " R9 stall valid"}, 32'(out_valid), 32'd1);
          chk({tag, " R9 stall data"}, out_data, ex);
          chk({tag, " R9 stall in_ready"}, 32'(in_ready), 32'd0);
          @(negedge clk);
        end
        out_ready = 1'b1;
      end
      #1;
      chk({tag, " valid"}, 32'(out_valid), 32'd1);
      chk({tag, " data"}, out_data, ex);
      chk({tag, " type"}, 32'(out_enc), 32'(k));
      @(negedge clk);
      if (xpnd_en) h = ror32(h, k ? int'(enc_rot) : int'(raw_rot));
    end
    #1;
    chk({tag, " emission count"}, 32'(out_valid), 32'd0);
    @(negedge clk);
  endtask

  task automatic set_vec(input logic [66:0] v);
    raw_cnt    = v[65:61]; enc_cnt = v[65:61];
    raw_rot    = v[60:56]; enc_rot = v[60:56];
    lane_rot   = v[55:41];
    lane_nbits = v[40:32];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < 3; l++) mdisp[l] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset in_ready", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 disabled in_ready", 32'(in_ready), 32'd0);
    @(negedge clk);

    // R2 pass-through, encoded type and counts ignored
    raw_cnt = 5'd5; enc_cnt = 5'd7;
    tx_en = 1'b1;
    @(negedge clk);
    run_word(32'hCAFE_F00D, 1'b1, 0, "R2 bypass enc");
    run_word(32'h0123_4567, 1'b0, 0, "R2 bypass raw");

    tx_en = 1'b0;
    @(negedge clk);
    xpnd_en = 1'b1;
    tx_en = 1'b1;
    @(negedge clk);

    // table: R3 raw repeat, R4 encoded repeat, R5 lane pick, R6/R7 symbols
    for (int v = 0; v < NV; v++) begin
      set_vec(VEC[v]);
      run_word(VEC[v][31:0], VEC[v][66], 0,
               VEC[v][66] ? $sformatf("R4 R5 R7 vec%0d", v) : $sformatf("R3 vec%0d", v));
    end

    // R9 stall on an encoded word, disparity must not move
    enc_cnt = 5'd2; enc_rot = 5'd8; lane_rot = {5'd16, 5'd8, 5'd0}; lane_nbits = '1;
    run_word(32'h3C5A_F00F, 1'b1, 4, "R9 R8 stall");

    // R6 long random encoded stream
    lane_rot = {5'd16, 5'd8, 5'd0}; lane_nbits = '1; enc_cnt = 5'd1;
    for (int i = 0; i < 300; i++) run_word($urandom, 1'b1, 0, "R6 random");

    // R8 disparity cleared by disable
    tx_en = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 off out_valid", 32'(out_valid), 32'd0);
    chk("R1 off in_ready", 32'(in_ready), 32'd0);
    @(negedge clk);
    tx_en = 1'b1;
    for (int l = 0; l < 3; l++) mdisp[l] = 0;
    @(negedge clk);
    run_word(32'h00FF_FFFF, 1'b1, 0, "R8 after clear");
    run_word(32'h0017_E3FF, 1'b1, 0, "R8 after clear 2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule